// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block produces one pulse-width modulated output from an 8-bit up-counting period timer. The timer is preceded by a prescaler, selectable as 1, 4 or 16, and a 2-bit quarter count. Together they give a 10-bit position inside each period, so the duty resolution is four times finer than the timer step. The period is set by an 8-bit limit. The duty is set by a 10-bit value given as an 8-bit upper part and a 2-bit lower part.

Software may change the duty inputs at any time. The block copies them into a shadow register only at the period boundary, so one period never mixes two duty values. The shadow and the live timer value are brought out for inspection. The output is registered and runs one clock behind the counter state. A zero duty keeps the line low. A duty that covers the whole period keeps it high.

Top module: `pwm_dbuf_top`

## Requirements
- R1: While rst_ni is low, tmr_o, duty_shadow_o and pwm_o are all zero.
- R2: Let ps be the prescale factor: 1 for presc_sel_i=2'b00, 4 for 2'b01, 16 for 2'b10 or 2'b11. Each period lasts (period_i+1)*4*ps clocks. During clock k of the period (k counted from 0), tmr_o equals k/(4*ps) rounded down, and it returns to 0 after reaching period_i.
- R3: duty_shadow_o takes the value {duty_hi_i, duty_lo_i} (upper part in bits 9:2) only on the clock edge that ends a period. At every other time it holds its value, whatever the duty inputs do.
- R4: Let D be the shadow value for a period. If D is 0, pwm_o stays low for that whole period. Otherwise pwm_o goes high one clock after the period starts.
- R5: If 0 < D*ps < period length, pwm_o is high for exactly D*ps clocks in each period. The high time is counted from the clock after the period start up to and including the first clock of the next period.
- R6: If D >= 4*(period_i+1), pwm_o is never cleared and stays high for the full period length.
- R7: While en_i is low, the counters and tmr_o hold their values and pwm_o is low from the next clock on. After en_i returns high, the count resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| period_i | input | 8 | Period limit for the timer |
| duty_hi_i | input | 8 | Duty value, upper 8 bits |
| duty_lo_i | input | 2 | Duty value, lower 2 bits |
| presc_sel_i | input | 2 | Prescale select: 00 gives 1, 01 gives 4, 1x gives 16 |
| pwm_o | output | 1 | PWM output |
| tmr_o | output | 8 | Current timer value |
| duty_shadow_o | output | 10 | Shadow duty value used for comparison |

## Verification
The hardest case to reach is a duty write that lands in the middle of a period. Such a write must leave both the shadow and the current pulse untouched until the boundary. The stimulus changes the duty inputs several clocks after a period start and checks the shadow on the very next clock. A behavioural model, which knows only clock positions inside the period, then confirms that the old high time finishes and the new one applies from the next period. The two extremes, a duty of zero and a duty equal to the full span, are run back to back. This exercises the one-clock trailing high pulse at the boundary between them.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    PS_1  = 2'b00,
    PS_4  = 2'b01,
    PS_16 = 2'b10
  } presc_e;

  localparam int unsigned PS_MAX_LOG = 4;

  // log2 of the prescale factor; 2'b11 aliases 16
  function automatic int unsigned presc_shift(logic [1:0] sel);
    case (sel)
      PS_1:    return 0;
      PS_4:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler import pwm_pkg::*; #(
  parameter int unsigned FINE_W = 2,
  localparam int unsigned PRE_W = FINE_W + PS_MAX_LOG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        sel_i,
  output logic              tick_o,
  output logic              zero_o,
  output logic [FINE_W-1:0] fine_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;
  int unsigned      shamt;

  always_comb begin
    shamt  = presc_shift(sel_i);
    limit  = PRE_W'((32'd1 << (FINE_W + shamt)) - 32'd1);
    fine_o = FINE_W'(cnt_q >> shamt);
  end

  assign tick_o = en_i && (cnt_q >= limit);
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  // step spans at least four clocks
  p_tick_sparse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] period_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             wrap_o
);
  logic [TMR_W-1:0] tmr_q;

  assign wrap_o = tick_i && (tmr_q == period_i);
  assign tmr_o  = tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (wrap_o) tmr_q <= '0;
    else if (tick_i) tmr_q <= tmr_q + 1'b1;
  end

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (tmr_q == '0));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wrap_o) |=> (tmr_q == $past(tmr_q) + 1'b1));
endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] shadow_o
);
  logic [DUTY_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (load_i) shadow_q <= duty_i;
  end

  assign shadow_o = shadow_q;

  p_shadow_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(shadow_q));
  p_shadow_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (shadow_q == $past(duty_i)));
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [DUTY_W-1:0] pos_i,
  input  logic [DUTY_W-1:0] shadow_i,
  output logic              pwm_o
);
  logic pwm_q;
  logic hit;

  assign hit = (pos_i == shadow_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pwm_q <= 1'b0;
    else if (!en_i)   pwm_q <= 1'b0;
    else if (start_i) pwm_q <= |shadow_i;
    else if (hit)     pwm_q <= 1'b0;
  end

  assign pwm_o = pwm_q;

  p_off_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_q);
  p_zero_duty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i && shadow_i == '0) |=> !pwm_q);
  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i && shadow_i != '0) |=> pwm_q);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i && hit) |=> !pwm_q);
endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top import pwm_pkg::*; #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FINE_W = 2,
  localparam int unsigned DUTY_W = TMR_W + FINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [TMR_W-1:0]  duty_hi_i,
  input  logic [FINE_W-1:0] duty_lo_i,
  input  logic [1:0]        presc_sel_i,
  output logic              pwm_o,
  output logic [TMR_W-1:0]  tmr_o,
  output logic [DUTY_W-1:0] duty_shadow_o
);
  logic              tick, pre_zero, wrap, start;
  logic [FINE_W-1:0] fine;
  logic [TMR_W-1:0]  tmr;
  logic [DUTY_W-1:0] shadow;

  pwm_prescaler #(.FINE_W(FINE_W)) u_pre (
    .clk_i, .rst_ni, .en_i, .sel_i(presc_sel_i),
    .tick_o(tick), .zero_o(pre_zero), .fine_o(fine)
  );

  pwm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .tick_i(tick), .period_i,
    .tmr_o(tmr), .wrap_o(wrap)
  );

  pwm_duty_buf #(.DUTY_W(DUTY_W)) u_buf (
    .clk_i, .rst_ni, .load_i(wrap),
    .duty_i({duty_hi_i, duty_lo_i}), .shadow_o(shadow)
  );

  // first clock of a period: timer and prescaler both at zero
  assign start = pre_zero && (tmr == '0);

  pwm_out #(.DUTY_W(DUTY_W)) u_out (
    .clk_i, .rst_ni, .en_i, .start_i(start),
    .pos_i({tmr, fine}), .shadow_i(shadow), .pwm_o
  );

  assign tmr_o         = tmr;
  assign duty_shadow_o = shadow;

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!pwm_o && tmr_o == '0 && duty_shadow_o == '0) || !rst_ni);
endmodule

// File: tb/tb_pwm_dbuf_top.sv
`timescale 1ns/1ps
module tb_pwm_dbuf_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] period = 8'd0;
  logic [7:0] duty_hi = 8'd0;
  logic [1:0] duty_lo = 2'd0;
  logic [1:0] sel = 2'd0;
  logic       pwm;
  logic [7:0] tmr;
  logic [9:0] shadow;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_dbuf_top dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_i(period),
    .duty_hi_i(duty_hi), .duty_lo_i(duty_lo), .presc_sel_i(sel),
    .pwm_o(pwm), .tmr_o(tmr), .duty_shadow_o(shadow)
  );

  function automatic int psf(logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : 16;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: clock position inside the period
  int m_pc, m_sh;
  bit m_pwm;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_sh = 0; m_pwm = 0;
    end else if (!en) begin
      m_pwm = 0;
    end else begin
      int ps, plen;
      ps = psf(sel);
      plen = (int'(period) + 1) * 4 * ps;
      if (m_pc == 0) m_pwm = (m_sh != 0);
      else if (m_pc / ps == m_sh) m_pwm = 0;
      if (m_pc >= plen - 1) begin
        m_pc = 0;
        m_sh = {duty_hi, duty_lo};
      end else m_pc++;
    end
  end

  // per-clock compare and per-period high time
  int hi_cnt, w_sh;
  bit win_ok;
  always @(negedge clk) begin
    if (!rst_n) begin
      win_ok = 0;
    end else if (!done) begin
      int ps, plen, exp_hi;
      ps = psf(sel);
      plen = (int'(period) + 1) * 4 * ps;
      check(int'(tmr) == m_pc / (4 * ps), "R2 tmr", int'(tmr), m_pc / (4 * ps));
      check(int'(shadow) == m_sh, "R3 shadow", int'(shadow), m_sh);
      check(pwm == m_pwm, "R5 pwm", int'(pwm), int'(m_pwm));
      if (!en) win_ok = 0;
      else begin
        if (m_pc == 1) begin
          if (win_ok) begin
            exp_hi = (w_sh * ps >= plen) ? plen : w_sh * ps;
            if (w_sh == 0)
              check(hi_cnt == 0, "R4 zero duty high time", hi_cnt, 0);
            else if (w_sh * ps >= plen)
              check(hi_cnt == exp_hi, "R6 full period high", hi_cnt, exp_hi);
            else
              check(hi_cnt == exp_hi, "R5 high time", hi_cnt, exp_hi);
          end
          hi_cnt = 0;
          w_sh = m_sh;
          win_ok = 1;
        end
        hi_cnt += int'(pwm);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_duty(int d);
    duty_hi = 8'(d >> 2);
    duty_lo = 2'(d);
  endtask

  task automatic restart(logic [1:0] s, logic [7:0] p, int d);
    rst_n = 1'b0;
    en = 1'b0;
    sel = s;
    period = p;
    set_duty(d);
    cyc(2);
    rst_n = 1'b1;
    en = 1'b1;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", wd, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(3);
    @(negedge clk);
    check(pwm == 0 && tmr == 0 && shadow == 0, "R1 reset", int'({pwm, tmr, shadow}), 0);
    @(posedge clk); #1;

    // R5: ps=1, period 4 (20 clocks), duty 7
    restart(2'b00, 8'd4, 7);
    cyc(120);
    // R6: duty equals span 4*(4+1)
    set_duty(20);
    cyc(100);
    // R4: duty 0 after full
    set_duty(0);
    cyc(80);

    // R3: mid-period change, ps=1, period 9 (40 clocks)
    restart(2'b00, 8'd9, 10);
    cyc(90);
    set_duty(33);
    @(negedge clk);
    check(int'(shadow) != 33, "R3 shadow unchanged mid-period", int'(shadow), 10);
    cyc(200);

    // R2/R5: ps=4, period 2 (48 clocks), duty 5 -> high 20
    restart(2'b01, 8'd2, 5);
    cyc(300);
    // R2/R5: ps=16 via 2'b11, period 1 (128 clocks), duty 3 -> high 48
    restart(2'b11, 8'd1, 3);
    cyc(700);
    // R6: duty beyond span, ps=16 via 2'b10, period 3
    restart(2'b10, 8'd3, 1023);
    cyc(900);

    // R7: enable low mid-period
    restart(2'b00, 8'd7, 13);
    cyc(75);
    begin
      logic [7:0] t0;
      en = 1'b0;
      cyc(1);
      t0 = tmr;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        check(pwm == 0, "R7 output low when disabled", int'(pwm), 0);
        check(tmr == t0, "R7 timer holds", int'(tmr), int'(t0));
      end
      @(posedge clk); #1;
      en = 1'b1;
    end
    cyc(200);

    // R5: period 255, ps=1, duty 1023 (last position matches)
    restart(2'b00, 8'd255, 1023);
    cyc(2100);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule